// File: doc/BRIEF.md
# UART Receive Idle and Ready Detector

This block is the status logic on the receive side of a UART. It watches the serial input for a run of whole idle frames and raises a sticky idle flag once the run is longer than a programmable length. The length is picked by a 2-bit code. A bit-sampling front end supplies a one-cycle tick per frame time and a strobe whenever it sees a start bit.

The block also compares the receive FIFO fill count against two separately programmed trigger levels. One drives a receiver-ready interrupt and the other drives a receive DMA request. Each output has its own enable. Both outputs are combinational, so they fall in the same cycle the fill count drops below the trigger or the enable is cleared.

The idle flag is write-one-to-clear. After it has been raised, it is disarmed until the next start bit marks new incoming data. A line that stays idle therefore reports one idle event per received burst.

Top module: `rx_status_monitor`

## Requirements
- R1: The idle limit is 4 frames for code 00, 8 for 01, 16 for 10 and 32 for 11. The idle flag rises at the clock edge that registers the frame tick bringing the idle run to limit+1, and not before.
- R2: A frame tick counts toward the run only while `rxd` is 1. A frame tick with `rxd` at 0 restarts the run at zero.
- R3: A `start_det` pulse zeroes the run and arms the idle flag, and it takes priority over a frame tick in the same cycle. Out of reset the flag is unarmed, so no idle run of any length sets it until a start bit has been seen.
- R4: The idle flag stays set until a cycle with `idle_clr` at 1, and it reads 0 from the next cycle on. After that it does not set again until a new `start_det` and a new full idle run.
- R5: When the flag sets in the same cycle that `idle_clr` is 1, the set wins and the flag reads 1.
- R6: `rdy_irq` is 1 exactly when `rdy_en` is 1, `fifo_level` is nonzero and `fifo_level >= rdy_trig`, with no register delay.
- R7: `dma_req` is 1 exactly when `dma_en` is 1, `fifo_level` is nonzero and `fifo_level >= dma_trig`, independently of the ready-interrupt settings and with no register delay.
- R8: With its enable at 0, `rdy_irq` (or `dma_req`) is 0 at every fill level.
- R9: After reset `idle_flag` is 0. With a fill level of 0, both `rdy_irq` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse per frame time |
| rxd | input | 1 | Receive line level, 1 = idle/mark |
| start_det | input | 1 | One-cycle pulse on a detected start bit |
| idle_code | input | 2 | Idle limit select: 4 << code frames |
| idle_clr | input | 1 | Write-one-to-clear pulse for the idle flag |
| fifo_level | input | LVL_W | Receive FIFO fill count |
| rdy_trig | input | LVL_W | Fill level that raises the ready interrupt |
| rdy_en | input | 1 | Ready interrupt enable |
| dma_trig | input | LVL_W | Fill level that raises the DMA request |
| dma_en | input | 1 | Receive DMA request enable |
| idle_flag | output | 1 | Sticky idle condition |
| rdy_irq | output | 1 | Receiver-ready interrupt |
| dma_req | output | 1 | Receive DMA request |

## Verification
For every code, the bench checks the flag one tick before the limit and again on the tick just past it. An off-by-one comparison would make the flag rise a frame early or a frame late. Runs are broken by a low tick and by a start strobe in the middle. A run counter that ignored the line level, or that missed the restart, would raise the flag too soon. The bench drives a long idle run before any start bit, and a second run after a clear, to catch a flag that is not disarmed. It also makes a set and a clear arrive together; if clear took priority, the idle event would be lost. The threshold table covers equality at the trigger level, a zero fill level with a zero trigger, the maximum count, and each enable held low. A comparison that was strict, or that ignored the enable, would misreport one of these rows.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    // Idle limit for code c is BASE_FRAMES << c
    localparam int BASE_FRAMES = 4;
    localparam int CODE_W      = 2;
    localparam int LIMIT_MAX   = BASE_FRAMES << ((1 << CODE_W) - 1);
    localparam int RUN_MAX     = LIMIT_MAX + 1;
    localparam int RUN_W       = $clog2(RUN_MAX + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             armed;
        logic             flag;
    } idle_state_t;
endpackage

// File: rtl/rxs_idle_tracker.sv
module rxs_idle_tracker
    import rxs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              rxd,
    input  logic              start_det,
    input  logic [CODE_W-1:0] idle_code,
    input  logic              idle_clr,
    output logic              idle_flag
);
    idle_state_t      st_d, st_q;
    logic [RUN_W-1:0] limit;
    logic             set_c;

    always_comb begin
        limit = RUN_W'(BASE_FRAMES) << idle_code;
        st_d  = st_q;
        set_c = 1'b0;
        if (start_det) begin
            st_d.run   = '0;
            st_d.armed = 1'b1;
        end else if (frame_tick) begin
            if (!rxd) begin
                st_d.run = '0;
            end else if (st_q.run != RUN_W'(RUN_MAX)) begin
                st_d.run = st_q.run + 1'b1;
            end
        end
        if (st_q.armed && !start_det && (st_d.run > limit)) begin
            set_c      = 1'b1;
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (idle_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_flag = st_q.flag;

    assert_run_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RUN_W'(RUN_MAX));
    assert_start_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st_q.run == '0) && st_q.armed);
    assert_set_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(st_q.armed));
    assert_clear_drops_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && !set_c) |=> !idle_flag);
    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && set_c) |=> idle_flag);
endmodule

// File: rtl/rxs_level_cmp.sv
module rxs_level_cmp #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    input  logic             en,
    output logic             hit
);
    always_comb begin
        hit = en && (level != '0) && (level >= trig);
    end
endmodule

// File: rtl/rx_status_monitor.sv
module rx_status_monitor
    import rxs_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              rxd,
    input  logic              start_det,
    input  logic [CODE_W-1:0] idle_code,
    input  logic              idle_clr,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [LVL_W-1:0]  rdy_trig,
    input  logic              rdy_en,
    input  logic [LVL_W-1:0]  dma_trig,
    input  logic              dma_en,
    output logic              idle_flag,
    output logic              rdy_irq,
    output logic              dma_req
);
    localparam int NUM_CMP = 2;

    logic [NUM_CMP-1:0][LVL_W-1:0] trig_v;
    logic [NUM_CMP-1:0]            en_v;
    logic [NUM_CMP-1:0]            hit_v;

    assign trig_v = {dma_trig, rdy_trig};
    assign en_v   = {dma_en, rdy_en};

    rxs_idle_tracker u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .rxd        (rxd),
        .start_det  (start_det),
        .idle_code  (idle_code),
        .idle_clr   (idle_clr),
        .idle_flag  (idle_flag)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        rxs_level_cmp #(.LVL_W(LVL_W)) u_cmp (
            .level (fifo_level),
            .trig  (trig_v[g]),
            .en    (en_v[g]),
            .hit   (hit_v[g])
        );
    end

    assign rdy_irq = hit_v[0];
    assign dma_req = hit_v[1];

    assert_rdy_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_en |-> !rdy_irq);
    assert_dma_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);
    assert_rdy_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_irq |-> (fifo_level >= rdy_trig) && (fifo_level != '0));
    assert_dma_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (fifo_level >= dma_trig) && (fifo_level != '0));
endmodule

// File: tb/tb_rx_status_monitor.sv
`timescale 1ns/1ps
module tb_rx_status_monitor;
    localparam int LVL_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0, rxd = 1'b1, start_det = 1'b0, idle_clr = 1'b0;
    logic [1:0] idle_code = 2'b00;
    logic [LVL_W-1:0] fifo_level = '0, rdy_trig = '0, dma_trig = '0;
    logic rdy_en = 1'b0, dma_en = 1'b0;
    logic idle_flag, rdy_irq, dma_req;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_status_monitor #(.LVL_W(LVL_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rxd(rxd),
        .start_det(start_det), .idle_code(idle_code), .idle_clr(idle_clr),
        .fifo_level(fifo_level), .rdy_trig(rdy_trig), .rdy_en(rdy_en),
        .dma_trig(dma_trig), .dma_en(dma_en),
        .idle_flag(idle_flag), .rdy_irq(rdy_irq), .dma_req(dma_req)
    );

    typedef struct packed {
        logic [5:0] lvl;
        logic [5:0] rt;
        logic       re;
        logic [5:0] dt;
        logic       de;
        logic       exp_rdy;
        logic       exp_dma;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{6'd5,  6'd4,  1'b1, 6'd8,  1'b1, 1'b1, 1'b0},
        '{6'd8,  6'd4,  1'b1, 6'd8,  1'b1, 1'b1, 1'b1},
        '{6'd3,  6'd4,  1'b1, 6'd2,  1'b1, 1'b0, 1'b1},
        '{6'd10, 6'd4,  1'b0, 6'd8,  1'b1, 1'b0, 1'b1},
        '{6'd10, 6'd4,  1'b1, 6'd8,  1'b0, 1'b1, 1'b0},
        '{6'd0,  6'd0,  1'b1, 6'd0,  1'b1, 1'b0, 1'b0},
        '{6'd1,  6'd0,  1'b1, 6'd1,  1'b1, 1'b1, 1'b1},
        '{6'd63, 6'd63, 1'b1, 6'd63, 1'b1, 1'b1, 1'b1},
        '{6'd62, 6'd63, 1'b1, 6'd63, 1'b1, 1'b0, 1'b0},
        '{6'd40, 6'd1,  1'b0, 6'd1,  1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input logic lvl);
        @(negedge clk);
        frame_tick = 1'b1;
        rxd = lvl;
        @(negedge clk);
        frame_tick = 1'b0;
        rxd = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        idle_clr = 1'b1;
        @(negedge clk);
        idle_clr = 1'b0;
    endtask

    task automatic limit_run(input logic [1:0] code, input string req);
        int lim;
        lim = 4 << code;
        idle_code = code;
        pulse_start();
        ticks(lim);
        chk(req, idle_flag, 1'b0);
        tick(1'b1);
        chk(req, idle_flag, 1'b1);
        pulse_clr();
        chk("R4", idle_flag, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9", idle_flag, 1'b0);
        rdy_en = 1'b1; dma_en = 1'b1;
        #1;
        chk("R9", rdy_irq, 1'b0);
        chk("R9", dma_req, 1'b0);

        // R6 R7 R8 threshold table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            fifo_level = VECS[v].lvl;
            rdy_trig = VECS[v].rt;  rdy_en = VECS[v].re;
            dma_trig = VECS[v].dt;  dma_en = VECS[v].de;
            #1;
            chk("R6/R8 rdy", rdy_irq, VECS[v].exp_rdy);
            chk("R7/R8 dma", dma_req, VECS[v].exp_dma);
        end
        // combinational drop below threshold: R6
        fifo_level = 6'd20; rdy_trig = 6'd20; rdy_en = 1'b1;
        #1; chk("R6", rdy_irq, 1'b1);
        fifo_level = 6'd19;
        #1; chk("R6", rdy_irq, 1'b0);

        // R3 unarmed out of reset: long idle run sets nothing
        idle_code = 2'b00;
        ticks(40);
        chk("R3", idle_flag, 1'b0);

        // R1 each code
        limit_run(2'b00, "R1");
        // R4 no re-set without new start
        ticks(10);
        chk("R4", idle_flag, 1'b0);
        limit_run(2'b01, "R1");
        limit_run(2'b10, "R1");
        limit_run(2'b11, "R1");

        // R2 low tick restarts run (code 01, limit 8)
        idle_code = 2'b01;
        pulse_start();
        ticks(6);
        tick(1'b0);
        ticks(8);
        chk("R2", idle_flag, 1'b0);
        tick(1'b1);
        chk("R2", idle_flag, 1'b1);
        pulse_clr();

        // R3 start mid-run restarts (code 00)
        idle_code = 2'b00;
        pulse_start();
        ticks(3);
        pulse_start();
        ticks(4);
        chk("R3", idle_flag, 1'b0);
        tick(1'b1);
        chk("R3", idle_flag, 1'b1);
        pulse_clr();

        // R3 start and tick together: start wins
        pulse_start();
        ticks(4);
        @(negedge clk);
        start_det = 1'b1; frame_tick = 1'b1;
        @(negedge clk);
        start_det = 1'b0; frame_tick = 1'b0;
        chk("R3", idle_flag, 1'b0);
        ticks(4);
        chk("R3", idle_flag, 1'b0);
        tick(1'b1);
        chk("R3", idle_flag, 1'b1);
        pulse_clr();

        // R5 set and clear in the same cycle
        pulse_start();
        ticks(4);
        @(negedge clk);
        frame_tick = 1'b1; idle_clr = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0; idle_clr = 1'b0;
        chk("R5", idle_flag, 1'b1);
        pulse_clr();
        chk("R4", idle_flag, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule